// File: doc/BRIEF.md
# Coalescing Acknowledgment Register-Scheduler

This block sits between the receive path of a transport engine and the header generator that builds acknowledgment packets. Each time the receive side decides that a queue pair should acknowledge a sequence number, it writes that number into a slot of a per-queue-pair memory addressed by the queue pair. If the queue pair is not already waiting, its index also joins a scheduling queue.

The scheduler drains that queue one entry at a time. For each entry it reads the slot, releases the waiting mark, and offers the queue pair index and sequence number on a valid/ready output. Writes that reach a waiting queue pair only replace the stored number. A burst of updates therefore leaves as a single acknowledgment carrying the newest value.

The write port has no back-pressure, so the receive side runs at full rate however slowly acknowledgments drain. The scheduling queue holds one entry per queue pair, which makes overflow impossible.

Top module: `acksch_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `ack_valid` is low.
- R2: A write to an idle queue pair, with the output stage empty, raises `ack_valid` on the second rising clock edge after the write is sampled, carrying that queue pair in `ack_qp` and the written number in `ack_psn`.
- R3: Several writes to one queue pair while it waits in the queue produce exactly one acknowledgment, and it carries the last value written.
- R4: Queue pairs are offered in the order in which each first became waiting. A rewrite of a waiting queue pair does not move it in that order.
- R5: A queue pair is never queued twice, and the queue never accepts an entry while full. After all acknowledgments have drained and no write arrives, `ack_valid` stays low.
- R6: A write to the queue pair being dequeued in the same cycle re-queues it. The dequeued acknowledgment carries the previous value, and a second acknowledgment later carries the new one.
- R7: While `ack_valid` is high and `ack_ready` is low, `ack_valid`, `ack_qp` and `ack_psn` hold their values.
- R8: The write port accepts a write on every cycle without back-pressure. With `ack_ready` high, writes on consecutive cycles alternating between queue pair 0 and queue pair 2047 each produce their own acknowledgment, in write order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid | input | 1 | Receive side registers a sequence number this cycle |
| upd_qp | input | QP_W (11) | Queue pair whose slot is written |
| upd_psn | input | PSN_W (24) | Acknowledged sequence number |
| ack_valid | output | 1 | An acknowledgment is offered |
| ack_ready | input | 1 | Header generator takes the offered acknowledgment |
| ack_qp | output | QP_W (11) | Queue pair to acknowledge |
| ack_psn | output | PSN_W (24) | Sequence number to place in the acknowledgment |

## Verification
The assertions check these properties on every cycle:
- the output holds while it is stalled;
- a dequeue always fills the output on the next edge;
- the queue never takes a push while full;
- a same-cycle write and dequeue of one queue pair leaves it queued again;
- reset clears the output.

Only the bench's scenarios can show which value comes out. That covers three cases:
- which value survives coalescing;
- the order of different queue pairs;
- the split into an old and a new acknowledgment when a write meets its own dequeue.

The same holds for the absence of duplicate acknowledgments after the queue drains.

// File: rtl/acksch_pkg.sv
`timescale 1ns/1ps
package acksch_pkg;

  // Advance a ring pointer, wrapping at depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // A write queues its queue pair when the pair is not waiting, or when the
  // pair is leaving the queue in this very cycle.
  function automatic logic need_enqueue(input logic wr, input logic waiting, input logic leaving);
    return wr && (!waiting || leaving);
  endfunction

endpackage

// File: rtl/acksch_slot_mem.sv
`timescale 1ns/1ps
module acksch_slot_mem #(
  parameter int SLOTS = 2048,
  parameter int DW    = 24,
  localparam int AW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (we) slot_q[waddr] <= wdata;
  end

  // Asynchronous read: the value present before this cycle's write.
  assign rdata = slot_q[raddr];
endmodule

// File: rtl/acksch_pend_bits.sv
`timescale 1ns/1ps
module acksch_pend_bits #(
  parameter int SLOTS = 2048,
  localparam int AW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_bit
);
  logic [SLOTS-1:0] wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (clr_en) wait_d[clr_idx] = 1'b0;
    if (set_en) wait_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  assign rd_bit = wait_q[rd_idx];
endmodule

// File: rtl/acksch_qfifo.sv
`timescale 1ns/1ps
module acksch_qfifo #(
  parameter int DEPTH = 2048,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  import acksch_pkg::*;

  logic [W-1:0]  ring_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (push) ring_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= AW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ring_next(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = ring_q[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
endmodule

// File: rtl/acksch_top.sv
`timescale 1ns/1ps
module acksch_top #(
  parameter int NUM_QP = 2048,
  parameter int PSN_W  = 24,
  localparam int QP_W  = $clog2(NUM_QP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [QP_W-1:0]  upd_qp,
  input  logic [PSN_W-1:0] upd_psn,
  output logic             ack_valid,
  input  logic             ack_ready,
  output logic [QP_W-1:0]  ack_qp,
  output logic [PSN_W-1:0] ack_psn
);
  import acksch_pkg::*;

  // Named internal events, used by the bound checker.
  logic             deq_fire;
  logic             enq_fire;
  logic [QP_W-1:0]  deq_qp;
  logic             fifo_empty;
  logic             fifo_full;
  logic             qp_waiting;
  logic             same_leaving;
  logic [PSN_W-1:0] slot_psn;

  acksch_slot_mem #(.SLOTS(NUM_QP), .DW(PSN_W)) u_mem (
    .clk   (clk),
    .we    (upd_valid),
    .waddr (upd_qp),
    .wdata (upd_psn),
    .raddr (deq_qp),
    .rdata (slot_psn)
  );

  acksch_pend_bits #(.SLOTS(NUM_QP)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (enq_fire),
    .set_idx (upd_qp),
    .clr_en  (deq_fire),
    .clr_idx (deq_qp),
    .rd_idx  (upd_qp),
    .rd_bit  (qp_waiting)
  );

  acksch_qfifo #(.DEPTH(NUM_QP), .W(QP_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (enq_fire),
    .push_data (upd_qp),
    .pop       (deq_fire),
    .head      (deq_qp),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  assign deq_fire     = !fifo_empty && (!ack_valid || ack_ready);
  assign same_leaving = deq_fire && (deq_qp == upd_qp);
  assign enq_fire     = need_enqueue(upd_valid, qp_waiting, same_leaving);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_qp    <= '0;
      ack_psn   <= '0;
    end else if (deq_fire) begin
      ack_valid <= 1'b1;
      ack_qp    <= deq_qp;
      ack_psn   <= slot_psn;
    end else if (ack_ready) begin
      ack_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/acksch_chk.sv
`timescale 1ns/1ps
module acksch_chk #(
  parameter int QP_W  = 11,
  parameter int PSN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic [QP_W-1:0]  upd_qp,
  input logic             ack_valid,
  input logic             ack_ready,
  input logic [QP_W-1:0]  ack_qp,
  input logic [PSN_W-1:0] ack_psn,
  input logic             deq_fire,
  input logic [QP_W-1:0]  deq_qp,
  input logic             enq_fire,
  input logic             fifo_empty,
  input logic             fifo_full
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !ack_valid);

  p_deq_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    deq_fire |=> ack_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> !fifo_full);

  p_requeue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && deq_fire && (upd_qp == deq_qp)) |=> !fifo_empty);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_qp) && $stable(ack_psn)));
endmodule

bind acksch_top acksch_chk #(.QP_W(QP_W), .PSN_W(PSN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_qp     (upd_qp),
  .ack_valid  (ack_valid),
  .ack_ready  (ack_ready),
  .ack_qp     (ack_qp),
  .ack_psn    (ack_psn),
  .deq_fire   (deq_fire),
  .deq_qp     (deq_qp),
  .enq_fire   (enq_fire),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full)
);

// File: tb/sim_acksch_top.sv
`timescale 1ns/1ps
module sim_acksch_top;
  localparam int NQ    = 2048;
  localparam int QP_W  = 11;
  localparam int PSN_W = 24;
  localparam int NVEC  = 8;

  // Each vector: {queue pair, sequence number}; expected ack echoes both.
  localparam logic [QP_W+PSN_W-1:0] VEC [NVEC] = '{
    {11'd0,    24'h000001},
    {11'd2047, 24'hFFFFFF},
    {11'd1,    24'h000000},
    {11'd1024, 24'h123456},
    {11'd77,   24'hABCDEF},
    {11'd2046, 24'h800000},
    {11'd5,    24'h000010},
    {11'd300,  24'h7FFFFF}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, upd_valid, ack_ready, ack_valid;
  logic [QP_W-1:0]  upd_qp, ack_qp;
  logic [PSN_W-1:0] upd_psn, ack_psn;

  acksch_top u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_qp(upd_qp),
    .upd_psn(upd_psn), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_qp(ack_qp), .ack_psn(ack_psn)
  );

  int total = 0;
  int bad   = 0;
  int cap_n = 0;
  logic [QP_W-1:0]  cap_qp  [256];
  logic [PSN_W-1:0] cap_psn [256];

  // Record each acknowledgment that will be taken at the next rising edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && ack_valid && ack_ready && cap_n < 256) begin
      cap_qp[cap_n]  = ack_qp;
      cap_psn[cap_n] = ack_psn;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input int qp, input int psn);
    upd_valid = 1'b1;
    upd_qp    = QP_W'(qp);
    upd_psn   = PSN_W'(psn);
    step(1);
    upd_valid = 1'b0;
  endtask

  task automatic chk_cap(input int idx, input int qp, input int psn, input string req);
    chk(cap_qp[idx] == QP_W'(qp), req, cap_qp[idx], qp);
    chk(cap_psn[idx] == PSN_W'(psn), req, cap_psn[idx], psn);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; upd_valid = 1'b0; upd_qp = '0; upd_psn = '0; ack_ready = 1'b0;
    step(3);
    @(negedge clk);
    chk(!ack_valid, "R1 in reset", ack_valid, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_valid, "R1 after release", ack_valid, 0);
    @(posedge clk); #2;

    // Table walk: one write per vector, ready high, expect one matching ack.
    ack_ready = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      base = cap_n;
      wr(int'(VEC[i][QP_W+PSN_W-1:PSN_W]), int'(VEC[i][PSN_W-1:0]));
      step(4);
      chk(cap_n == base + 1, "R8 one ack per vector", cap_n - base, 1);
      chk_cap(base, int'(VEC[i][QP_W+PSN_W-1:PSN_W]), int'(VEC[i][PSN_W-1:0]), "R2 vector");
    end

    // Latency with ready low, then hold, coalescing and order.
    ack_ready = 1'b0;
    wr(5, 'h100);
    @(negedge clk);
    chk(!ack_valid, "R2 not yet valid after first edge", ack_valid, 0);
    @(negedge clk);
    chk(ack_valid && ack_qp == 5 && ack_psn == 'h100, "R2 valid after second edge", {ack_valid, ack_qp}, {1'b1, 11'd5});
    @(posedge clk); #2;
    wr(5, 'h101);
    wr(9, 1); wr(9, 2); wr(9, 3);
    wr(12, 7); wr(3, 8); wr(12, 9);
    @(negedge clk);
    chk(ack_valid && ack_qp == 5 && ack_psn == 'h100, "R7 held while stalled", ack_psn, 'h100);
    @(posedge clk); #2;
    base = cap_n;
    ack_ready = 1'b1;
    step(12);
    chk(cap_n == base + 5, "R5 no duplicate acks", cap_n - base, 5);
    chk_cap(base + 0, 5, 'h100, "R7 stalled value delivered");
    chk_cap(base + 1, 5, 'h101, "R4 requeued after dequeue");
    chk_cap(base + 2, 9, 3, "R3 last value wins");
    chk_cap(base + 3, 12, 9, "R4 order kept on rewrite");
    chk_cap(base + 4, 3, 8, "R4 order of arrival");

    // Write meets its own dequeue.
    base = cap_n;
    wr(20, 'h10);
    wr(20, 'h11);
    step(6);
    chk(cap_n == base + 2, "R6 two acks", cap_n - base, 2);
    chk_cap(base + 0, 20, 'h10, "R6 old value first");
    chk_cap(base + 1, 20, 'h11, "R6 new value second");

    // Idle: nothing more comes out.
    base = cap_n;
    step(10);
    chk(cap_n == base, "R5 idle no ack", cap_n - base, 0);
    @(negedge clk);
    chk(!ack_valid, "R5 idle valid low", ack_valid, 0);
    @(posedge clk); #2;

    // Back-to-back writes at the index boundaries.
    base = cap_n;
    wr(0, 1); wr(2047, 2); wr(0, 3); wr(2047, 4);
    step(8);
    chk(cap_n == base + 4, "R8 every write acked", cap_n - base, 4);
    chk_cap(base + 0, 0, 1, "R8 first");
    chk_cap(base + 1, 2047, 2, "R8 second");
    chk_cap(base + 2, 0, 3, "R8 third");
    chk_cap(base + 3, 2047, 4, "R8 fourth");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule